// File: doc/BRIEF.md
# Panel vertical sync timing generator

This block produces the vertical timing for a display panel. It counts lines from a one-clock line strobe supplied by the horizontal timing logic. From that count it drives an active-low vertical sync pulse. It also drives a one-clock strobe that tells the image fetch logic to begin reading the frame, plus a flag that stays high while image lines are being read.

Software sets the timing through a 32-bit control word. The word carries a sync pulse width and a read-start offset, both in lines.

Writes land in a staging copy that software can read back at once. The timing logic uses a separate working copy. That working copy is refreshed from the staging copy only on the line strobe that starts a new frame. A new setting therefore never changes a frame already in progress.

The pulse width is counted from the falling edge of the sync pulse. The read-start offset is counted from its rising edge. The frame length in lines is a parameter.

Top module: `panel_vtiming`

## Requirements
- R1: During and after synchronous reset (`rst` high), the outputs take these values: `vsync_n` is 1, `read_start` is 0 and `image_active` is 0. The line count is 0. Both copies hold width 3 and offset 4, so `rd_data` reads 32'h0000_3004.
- R2: A cycle with `wr_en` high loads `wr_data[15:12]` as the pulse width and `wr_data[8:0]` as the read-start offset into the staging copy. From the next cycle, `rd_data` returns the width in bits 15:12 and the offset in bits 8:0. All other bits of `rd_data` read 0, and bits 31:16 and 11:9 of `wr_data` have no effect.
- R3: A written pulse width of 0 is stored as 1, so it reads back as 1 and acts as a one-line pulse.
- R4: Each cycle with `line_tick` high advances the line count by one. After line FRAME_LINES-1 the count wraps to 0. Cycles without `line_tick` leave the count and all outputs other than `read_start` unchanged.
- R5: `vsync_n` goes low in the cycle after the tick on which the count wraps to 0. It returns high in the cycle after the tick on which the count reaches the working pulse width W. It is therefore low for lines 0 to W-1.
- R6: `read_start` is high for exactly one cycle, following the tick on which the count equals W plus the working offset. `image_active` rises together with `read_start`. It falls after the next wrap tick.
- R7: The working copy is loaded from the staging copy only on the wrap tick. A write during a frame leaves that frame's timing unchanged, and the new values apply from the next frame.
- R8: When W plus the offset is FRAME_LINES or more, no `read_start` occurs in that frame, and `image_active` stays low for the whole frame.
- R9: In the partial frame between reset and the first wrap, `vsync_n` stays high. `read_start` and `image_active` still follow the working copy as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_tick | input | 1 | One-clock strobe per line boundary |
| wr_en | input | 1 | Control word write enable |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Staging copy of the control word |
| vsync_n | output | 1 | Vertical sync, active low |
| read_start | output | 1 | One-clock image read start strobe |
| image_active | output | 1 | High from read start to end of frame |

## Verification
The bench builds the block with FRAME_LINES set to 20, so that many full frames fit in a short run. With that frame length, the largest pulse width of 15 and the offsets that push the strobe onto the last line, or just past it, are all reachable within one frame. A 9-bit offset of 511 is also tried, which is far beyond the frame. Each frame is preceded by a mid-frame write of the next setting. This shows, on every frame, that new values wait for the wrap.

// File: rtl/panel_vt_pkg.sv
package panel_vt_pkg;

    localparam int CTRL_W    = 32;
    localparam int WIDTH_W   = 4;
    localparam int OFFSET_W  = 9;
    localparam int WIDTH_LSB = 12;
    localparam int OFFSET_LSB = 0;

    localparam logic [WIDTH_W-1:0]  WIDTH_RST  = 4'd3;
    localparam logic [OFFSET_W-1:0] OFFSET_RST = 9'd4;

    typedef struct packed {
        logic [WIDTH_W-1:0]  width;
        logic [OFFSET_W-1:0] offset;
    } vt_cfg_t;

    localparam vt_cfg_t CFG_RST = '{width: WIDTH_RST, offset: OFFSET_RST};

endpackage

// File: rtl/panel_vt_cfg.sv
module panel_vt_cfg
    import panel_vt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              load,
    output vt_cfg_t           work_cfg,
    output logic [CTRL_W-1:0] rd_data
);

    typedef struct packed {
        vt_cfg_t stage;
        vt_cfg_t work;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [WIDTH_W-1:0]  wr_width;
    logic [OFFSET_W-1:0] wr_offset;
    logic                unused_rsvd;

    assign wr_width    = wr_data[WIDTH_LSB +: WIDTH_W];
    assign wr_offset   = wr_data[OFFSET_LSB +: OFFSET_W];
    assign unused_rsvd = ^{wr_data[CTRL_W-1:WIDTH_LSB+WIDTH_W],
                           wr_data[WIDTH_LSB-1:OFFSET_LSB+OFFSET_W]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.stage.width  = (wr_width == '0) ? WIDTH_W'(1) : wr_width;
            st_d.stage.offset = wr_offset;
        end
        if (load) begin
            st_d.work = st_q.stage;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{stage: CFG_RST, work: CFG_RST};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[WIDTH_LSB +: WIDTH_W]   = st_q.stage.width;
        rd_data[OFFSET_LSB +: OFFSET_W] = st_q.stage.offset;
    end

    assign work_cfg = st_q.work;

    assert_work_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(st_q.work));

    assert_zero_clamp_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[WIDTH_LSB +: WIDTH_W] == '0) |=> (rd_data[WIDTH_LSB +: WIDTH_W] == WIDTH_W'(1)));

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        rd_data[CTRL_W-1:WIDTH_LSB+WIDTH_W] == '0);

endmodule

// File: rtl/panel_vt_linecnt.sv
module panel_vt_linecnt #(
    parameter int FRAME_LINES = 525,
    localparam int LINE_W = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic              frame_start,
    output logic [LINE_W-1:0] nxt_line
);

    localparam logic [LINE_W-1:0] LAST = LINE_W'(FRAME_LINES - 1);

    typedef struct packed {
        logic [LINE_W-1:0] line;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       at_last;

    assign at_last = (st_q.line == LAST);

    always_comb begin
        st_d     = st_q;
        nxt_line = at_last ? '0 : st_q.line + LINE_W'(1);
        if (tick) begin
            st_d.line = nxt_line;
        end
    end

    assign frame_start = tick && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_line_range_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.line <= LAST);

    assert_line_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st_q.line));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (st_q.line == '0));

endmodule

// File: rtl/panel_vt_sync.sv
module panel_vt_sync
    import panel_vt_pkg::*;
#(
    parameter int LINE_W = 10,
    localparam int SUM_W = ((LINE_W > OFFSET_W) ? LINE_W : OFFSET_W) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              frame_start,
    input  logic [LINE_W-1:0] nxt_line,
    input  vt_cfg_t           cfg,
    output logic              vsync_n,
    output logic              read_start,
    output logic              image_active
);

    typedef struct packed {
        logic vs_n;
        logic rs;
        logic act;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic [SUM_W-1:0] line_ext;
    logic [SUM_W-1:0] rise_line;
    logic [SUM_W-1:0] start_line;

    assign line_ext   = SUM_W'(nxt_line);
    assign rise_line  = SUM_W'(cfg.width);
    assign start_line = SUM_W'(cfg.width) + SUM_W'(cfg.offset);

    always_comb begin
        st_d    = st_q;
        st_d.rs = 1'b0;
        if (tick) begin
            if (frame_start) begin
                st_d.vs_n = 1'b0;
                st_d.act  = 1'b0;
            end else begin
                if (line_ext == rise_line) begin
                    st_d.vs_n = 1'b1;
                end
                if (line_ext == start_line) begin
                    st_d.rs  = 1'b1;
                    st_d.act = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{vs_n: 1'b1, rs: 1'b0, act: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vsync_n      = st_q.vs_n;
    assign read_start   = st_q.rs;
    assign image_active = st_q.act;

    assert_fall_at_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |-> $past(frame_start));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        read_start |=> !read_start);

    assert_strobe_active_R6: assert property (@(posedge clk) disable iff (rst)
        read_start |-> image_active);

    assert_active_clear_R6: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !image_active);

    assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(vsync_n) && $stable(image_active) && !read_start));

endmodule

// File: rtl/panel_vtiming.sv
module panel_vtiming
    import panel_vt_pkg::*;
#(
    parameter int FRAME_LINES = 525,
    localparam int LINE_W = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_tick,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              vsync_n,
    output logic              read_start,
    output logic              image_active
);

    logic              frame_start;
    logic [LINE_W-1:0] nxt_line;
    vt_cfg_t           work_cfg;

    panel_vt_linecnt #(.FRAME_LINES(FRAME_LINES)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (line_tick),
        .frame_start (frame_start),
        .nxt_line    (nxt_line)
    );

    panel_vt_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .load     (frame_start),
        .work_cfg (work_cfg),
        .rd_data  (rd_data)
    );

    panel_vt_sync #(.LINE_W(LINE_W)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .tick         (line_tick),
        .frame_start  (frame_start),
        .nxt_line     (nxt_line),
        .cfg          (work_cfg),
        .vsync_n      (vsync_n),
        .read_start   (read_start),
        .image_active (image_active)
    );

endmodule

// File: tb/panel_vtiming_tb_top.sv
module panel_vtiming_tb_top;

    localparam int LINES = 20;
    localparam int NV    = 7;

    localparam logic [31:0] VEC_WR [NV] = '{32'hA5A5_3E04, 32'h0000_1000, 32'h0000_F004,
                                            32'hFFFF_500F, 32'h0000_2011, 32'h0000_0002,
                                            32'h0000_71FF};
    localparam logic [31:0] VEC_RD [NV] = '{32'h0000_3004, 32'h0000_1000, 32'h0000_F004,
                                            32'h0000_500F, 32'h0000_2011, 32'h0000_1002,
                                            32'h0000_71FF};
    localparam int VEC_RISE [NV] = '{3, 1, 15, 5, 2, 1, 7};
    localparam int VEC_STRB [NV] = '{7, 1, 19, -1, 19, 3, -1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        vsync_n, read_start, image_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    panel_vtiming #(.FRAME_LINES(LINES)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .line_tick    (line_tick),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .vsync_n      (vsync_n),
        .read_start   (read_start),
        .image_active (image_active)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_tick();
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
    endtask

    task automatic do_write(input logic [31:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) begin wr_en = 1'b0; wr_data = '0; end
    endtask

    task automatic run_frame(input int k);
        int bad_vs = 0, bad_rs = 0, bad_act = 0;
        for (int i = 0; i < LINES; i++) begin
            do_tick();
            if (vsync_n !== ((i < VEC_RISE[k]) ? 1'b0 : 1'b1)) bad_vs++;
            if (read_start !== (i == VEC_STRB[k])) bad_rs++;
            if (image_active !== (VEC_STRB[k] >= 0 && i >= VEC_STRB[k])) bad_act++;
            @(negedge clk);
            if (read_start !== 1'b0) bad_rs++;
            if (i == 10 && k + 1 < NV) begin
                do_write(VEC_WR[k+1]);
                check(rd_data == VEC_RD[k+1], "R2/R3 readback", rd_data, VEC_RD[k+1]);
            end
        end
        check(bad_vs == 0, "R5/R7 vsync_n per line", bad_vs, 0);
        check(bad_rs == 0, (VEC_STRB[k] < 0) ? "R8 no read_start" : "R6 read_start line", bad_rs, 0);
        check(bad_act == 0, (VEC_STRB[k] < 0) ? "R8 image_active low" : "R6 image_active span", bad_act, 0);
    endtask

    initial begin
        int hi_bad;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(vsync_n == 1'b1, "R1 vsync_n", vsync_n, 1);
        check(read_start == 1'b0, "R1 read_start", read_start, 0);
        check(image_active == 1'b0, "R1 image_active", image_active, 0);
        check(rd_data == 32'h0000_3004, "R1 rd_data", rd_data, 32'h3004);
        rst = 1'b0;
        @(negedge clk);
        check(vsync_n == 1'b1 && rd_data == 32'h0000_3004, "R1 after release", rd_data, 32'h3004);

        // R9: partial frame after reset, lines 1..19; R4: idle cycles change nothing
        hi_bad = 0;
        for (int i = 1; i < LINES; i++) begin
            do_tick();
            if (vsync_n !== 1'b1) hi_bad++;
            repeat (2) @(negedge clk);
            if (vsync_n !== 1'b1 || read_start !== 1'b0) hi_bad++;
            if (i == 8) check(image_active == 1'b1, "R9 reset-frame image_active", image_active, 1);
        end
        check(hi_bad == 0, "R9 vsync_n high in reset frame", hi_bad, 0);

        do_write(VEC_WR[0]);
        check(rd_data == VEC_RD[0], "R2 reserved bits ignored", rd_data, VEC_RD[0]);

        for (int k = 0; k < NV; k++) run_frame(k);

        // R1: reset mid-frame restores defaults
        do_tick();
        do_tick();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check(rd_data == 32'h0000_3004, "R1 re-reset rd_data", rd_data, 32'h3004);
        check(vsync_n == 1'b1 && image_active == 1'b0, "R1 re-reset outputs", {vsync_n, image_active}, 2'b10);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule